// File: doc/BRIEF.md
# Virtual Address Translation Front End

This block turns one virtual address per cycle into a physical address for an instruction fetch or a data access, or into a typed fault with the fields an exception handler needs. It works out the processor operating mode from a status word. Two kernel segments need no table lookup: the cached one and the uncached one. For these the block strips the segment base directly. Every other address is mapped. For a mapped address the block forms a virtual page number and presents it, with the address-space identifier, on a lookup port. An external translation table answers on that port in the same cycle.

When the table reports a hit, the block picks the even or odd half of the paired-page entry using the address bit at the entry's page-size shift. It then checks the valid bit of that half, and the dirty bit too for data accesses. If both checks succeed it assembles the physical address from the selected frame number and the page offset. It also flags the result as uncacheable when the address falls in the uncached region. Only one fault is reported per access, following a fixed priority. Results are registered and appear one cycle after the request.

Top module: `vat_xlate`

## Requirements
- R1: `rsp_mode` reports the mode decoded from `status_word`. It is 0 (kernel) when any bit of 0x10000006 is set or bits [4:3] are 00. Otherwise it is 1 (supervisor) for [4:3]=01, 2 (user) for 10 and 3 (invalid) for 11.
- R2: An address whose top three bits are 100 bypasses the table and yields paddr = vaddr & 0x1FFFFFFF. If the mode is not kernel, or the access is misaligned, it instead faults with code 1 (instruction) or 2 (data).
- R3: An address whose top three bits are 101 bypasses the table, never faults, ignores the misaligned flag and the mode, and yields paddr = vaddr & 0x1FFFFFFF.
- R4: For a mapped address, `tlb_vpn` = vaddr >> 11 with bits [1:0] forced to 0 unless `small_pages` is 1, and `tlb_asid` = `req_asid`. Both are combinational.
- R5: A misaligned mapped access faults with code 1 (instruction) or 2 (data), ahead of any table result.
- R6: A mapped access that misses in the table faults with code 3 (instruction) or 4 (data).
- R7: On a hit, vaddr bit `tlb_shift` selects the half: 0 selects even and 1 selects odd. If the valid bit of the selected half is 0, the access faults with code 5 (instruction) or 6 (data).
- R8: A data access that hits a valid half whose dirty bit is 0 faults with code 7. Instruction accesses ignore the dirty bit.
- R9: On any fault, `rsp_badvaddr` is the virtual address, and on non-faulting results it is 0. For fault codes 3 to 7 the response also carries the request ASID, VPN2 = VPN>>2, VPN2X = VPN[1:0] and the context field = VPN>>2. For other results these fields are 0.
- R10: On a successful mapped translation, paddr = ((pfn >> (shift-12)) << shift) | (vaddr & `tlb_offmask`), where pfn is the selected half's frame number in 4 KiB units.
- R11: `rsp_uncached` is 1 only on a non-faulting result whose vaddr has all bits of 0xA0000000 set. On a fault, `rsp_paddr` and `rsp_uncached` are 0. Fault code 0 means no fault.
- R12: Each response is registered, so `rsp_valid` follows `req_valid` one cycle later. Reset clears every response output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space identifier |
| req_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_misaligned | input | 1 | Access is misaligned |
| status_word | input | 32 | Processor status word |
| small_pages | input | 1 | Small-page mode enable |
| tlb_vpn | output | 21 | Page number presented to the table |
| tlb_asid | output | 8 | ASID presented to the table |
| tlb_hit | input | 1 | Table matched the entry |
| tlb_shift | input | 5 | Page-size shift of the matched entry (12 or more) |
| tlb_pfn_even | input | 20 | Even-half frame number |
| tlb_pfn_odd | input | 20 | Odd-half frame number |
| tlb_valid_even | input | 1 | Even-half valid |
| tlb_valid_odd | input | 1 | Odd-half valid |
| tlb_dirty_even | input | 1 | Even-half dirty (writable) |
| tlb_dirty_odd | input | 1 | Odd-half dirty (writable) |
| tlb_offmask | input | 32 | Page offset mask of the entry |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 3 | Fault code, 0 = none |
| rsp_mode | output | 2 | Decoded mode |
| rsp_paddr | output | 32 | Physical address |
| rsp_uncached | output | 1 | Result is uncacheable |
| rsp_asid | output | 8 | Reported ASID |
| rsp_vpn2 | output | 19 | Reported VPN2 |
| rsp_vpn2x | output | 2 | Reported VPN2 extension |
| rsp_badvaddr | output | 32 | Reported faulting address |
| rsp_ctx_badvpn2 | output | 19 | Reported context page number |

## Verification
The kernel-segment cases change the status word across all four mode encodings, including one word where the mask bits override bits [4:3]. This separates the mode decoder from the address-error decision. The mapped cases use the same address in two ways. Toggling the small-page flag shows the low VPN bits kept or cleared. Driving the even and odd halves with different frame numbers, valid bits and dirty bits shows which half was chosen and which bit gated the result. Misaligned requests sent with a hitting entry confirm the fault priority. A large page with a wider shift and offset mask confirms the frame alignment arithmetic. A mapped address in the top region, sent once as a hit and once as a miss, shows that the uncached flag applies only to successful translations.

// File: rtl/vat_pkg.sv
package vat_pkg;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_ADDR_FETCH = 3'd1,
        FLT_ADDR_STORE = 3'd2,
        FLT_REFILL_I   = 3'd3,
        FLT_REFILL_D   = 3'd4,
        FLT_INVAL_I    = 3'd5,
        FLT_INVAL_D    = 3'd6,
        FLT_MODIFIED   = 3'd7
    } fault_e;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_SUPER  = 2'd1,
        MODE_USER   = 2'd2,
        MODE_BAD    = 2'd3
    } mode_e;

    localparam logic [31:0] KERN_FORCE_MASK = 32'h1000_0006;
    localparam logic [31:0] UNCACHED_MASK   = 32'hA000_0000;
    localparam int          VPN_LSB         = 11;
    localparam int          FRAME_LSB       = 12;

endpackage

// File: rtl/vat_mode_dec.sv
module vat_mode_dec
    import vat_pkg::*;
(
    input  logic [31:0] status,
    output mode_e       mode
);
    logic forced_kernel;

    always_comb begin
        forced_kernel = |(status & KERN_FORCE_MASK);
        if (forced_kernel || status[4:3] == 2'b00) begin
            mode = MODE_KERNEL;
        end else begin
            case (status[4:3])
                2'b01:   mode = MODE_SUPER;
                2'b10:   mode = MODE_USER;
                default: mode = MODE_BAD;
            endcase
        end
    end
endmodule

// File: rtl/vat_seg_dec.sv
module vat_seg_dec
    import vat_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input  logic [VA_W-1:0] vaddr,
    output logic            in_cached_kseg,
    output logic            in_uncached_kseg,
    output logic            uncached_region,
    output logic [PA_W-1:0] direct_pa
);
    localparam int SEG_LSB = VA_W - 3;

    logic [VA_W-1:0] unc_mask;

    always_comb begin
        unc_mask         = VA_W'(UNCACHED_MASK);
        in_cached_kseg   = (vaddr[VA_W-1:SEG_LSB] == 3'b100);
        in_uncached_kseg = (vaddr[VA_W-1:SEG_LSB] == 3'b101);
        uncached_region  = ((vaddr & unc_mask) == unc_mask);
        direct_pa        = PA_W'(vaddr[SEG_LSB-1:0]);
    end
endmodule

// File: rtl/vat_page_sel.sv
module vat_page_sel
    import vat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PFN_W   = 20,
    parameter int SHIFT_W = 5
) (
    input  logic [VA_W-1:0]    vaddr,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [PFN_W-1:0]   pfn_even,
    input  logic [PFN_W-1:0]   pfn_odd,
    input  logic               valid_even,
    input  logic               valid_odd,
    input  logic               dirty_even,
    input  logic               dirty_odd,
    input  logic [VA_W-1:0]    offmask,
    output logic               half_odd,
    output logic               half_valid,
    output logic               half_dirty,
    output logic [PA_W-1:0]    paddr
);
    logic [VA_W-1:0]    shifted_va;
    logic [PFN_W-1:0]   pfn_sel;
    logic [PA_W-1:0]    frame;
    logic [SHIFT_W-1:0] align_amt;

    always_comb begin
        shifted_va = vaddr >> shift;
        half_odd   = shifted_va[0];
        pfn_sel    = half_odd ? pfn_odd   : pfn_even;
        half_valid = half_odd ? valid_odd : valid_even;
        half_dirty = half_odd ? dirty_odd : dirty_even;
        align_amt  = shift - SHIFT_W'(FRAME_LSB);
        frame      = (PA_W'(pfn_sel) >> align_amt) << shift;
        paddr      = frame | PA_W'(vaddr & offmask);
    end
endmodule

// File: rtl/vat_xlate.sv
module vat_xlate
    import vat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int SHIFT_W = 5,
    localparam int VPN_W  = VA_W - VPN_LSB,
    localparam int VPN2_W = VPN_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic               req_is_data,
    input  logic               req_misaligned,
    input  logic [31:0]        status_word,
    input  logic               small_pages,
    output logic [VPN_W-1:0]   tlb_vpn,
    output logic [ASID_W-1:0]  tlb_asid,
    input  logic               tlb_hit,
    input  logic [SHIFT_W-1:0] tlb_shift,
    input  logic [PFN_W-1:0]   tlb_pfn_even,
    input  logic [PFN_W-1:0]   tlb_pfn_odd,
    input  logic               tlb_valid_even,
    input  logic               tlb_valid_odd,
    input  logic               tlb_dirty_even,
    input  logic               tlb_dirty_odd,
    input  logic [VA_W-1:0]    tlb_offmask,
    output logic               rsp_valid,
    output logic [2:0]         rsp_fault,
    output logic [1:0]         rsp_mode,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_uncached,
    output logic [ASID_W-1:0]  rsp_asid,
    output logic [VPN2_W-1:0]  rsp_vpn2,
    output logic [1:0]         rsp_vpn2x,
    output logic [VA_W-1:0]    rsp_badvaddr,
    output logic [VPN2_W-1:0]  rsp_ctx_badvpn2
);
    typedef struct packed {
        logic              valid;
        logic [2:0]        fault;
        logic [1:0]        mode;
        logic [PA_W-1:0]   paddr;
        logic              uncached;
        logic [ASID_W-1:0] asid;
        logic [VPN2_W-1:0] vpn2;
        logic [1:0]        vpn2x;
        logic [VA_W-1:0]   badvaddr;
        logic [VPN2_W-1:0] ctx;
    } rsp_t;

    mode_e           mode;
    logic            in_ck, in_uk, unc_region;
    logic [PA_W-1:0] direct_pa;
    logic            half_odd, half_valid, half_dirty;
    logic [PA_W-1:0] mapped_pa;
    logic [VPN_W-1:0] vpn;
    logic            tlb_fault;
    rsp_t            rsp_d, rsp_q;

    vat_mode_dec u_mode (
        .status (status_word),
        .mode   (mode)
    );

    vat_seg_dec #(.VA_W(VA_W), .PA_W(PA_W)) u_seg (
        .vaddr            (req_vaddr),
        .in_cached_kseg   (in_ck),
        .in_uncached_kseg (in_uk),
        .uncached_region  (unc_region),
        .direct_pa        (direct_pa)
    );

    vat_page_sel #(
        .VA_W(VA_W), .PA_W(PA_W), .PFN_W(PFN_W), .SHIFT_W(SHIFT_W)
    ) u_page (
        .vaddr      (req_vaddr),
        .shift      (tlb_shift),
        .pfn_even   (tlb_pfn_even),
        .pfn_odd    (tlb_pfn_odd),
        .valid_even (tlb_valid_even),
        .valid_odd  (tlb_valid_odd),
        .dirty_even (tlb_dirty_even),
        .dirty_odd  (tlb_dirty_odd),
        .offmask    (tlb_offmask),
        .half_odd   (half_odd),
        .half_valid (half_valid),
        .half_dirty (half_dirty),
        .paddr      (mapped_pa)
    );

    // Lookup-port page number: low pair cleared unless small pages.
    always_comb begin
        vpn = req_vaddr[VA_W-1:VPN_LSB];
        if (!small_pages) begin
            vpn[1:0] = 2'b00;
        end
        tlb_vpn  = vpn;
        tlb_asid = req_asid;
    end

    always_comb begin
        rsp_d     = '0;
        tlb_fault = 1'b0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.mode  = mode;
            if (in_ck) begin
                if (mode != MODE_KERNEL || req_misaligned) begin
                    rsp_d.fault = req_is_data ? FLT_ADDR_STORE : FLT_ADDR_FETCH;
                end else begin
                    rsp_d.paddr    = direct_pa;
                    rsp_d.uncached = unc_region;
                end
            end else if (in_uk) begin
                rsp_d.paddr    = direct_pa;
                rsp_d.uncached = unc_region;
            end else if (req_misaligned) begin
                rsp_d.fault = req_is_data ? FLT_ADDR_STORE : FLT_ADDR_FETCH;
            end else if (!tlb_hit) begin
                rsp_d.fault = req_is_data ? FLT_REFILL_D : FLT_REFILL_I;
                tlb_fault   = 1'b1;
            end else if (!half_valid) begin
                rsp_d.fault = req_is_data ? FLT_INVAL_D : FLT_INVAL_I;
                tlb_fault   = 1'b1;
            end else if (req_is_data && !half_dirty) begin
                rsp_d.fault = FLT_MODIFIED;
                tlb_fault   = 1'b1;
            end else begin
                rsp_d.paddr    = mapped_pa;
                rsp_d.uncached = unc_region;
            end

            if (rsp_d.fault != FLT_NONE) begin
                rsp_d.badvaddr = req_vaddr;
            end
            if (tlb_fault) begin
                rsp_d.asid  = req_asid;
                rsp_d.vpn2  = vpn[VPN_W-1:2];
                rsp_d.vpn2x = vpn[1:0];
                rsp_d.ctx   = vpn[VPN_W-1:2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    // half_odd is consumed inside the page selector; kept visible here.
    logic unused_half;
    assign unused_half = half_odd;

    assign rsp_valid       = rsp_q.valid;
    assign rsp_fault       = rsp_q.fault;
    assign rsp_mode        = rsp_q.mode;
    assign rsp_paddr       = rsp_q.paddr;
    assign rsp_uncached    = rsp_q.uncached;
    assign rsp_asid        = rsp_q.asid;
    assign rsp_vpn2        = rsp_q.vpn2;
    assign rsp_vpn2x       = rsp_q.vpn2x;
    assign rsp_badvaddr    = rsp_q.badvaddr;
    assign rsp_ctx_badvpn2 = rsp_q.ctx;
endmodule

// File: rtl/vat_xlate_chk.sv
module vat_xlate_chk #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int VPN_W  = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_misaligned,
    input logic             small_pages,
    input logic [VPN_W-1:0] tlb_vpn,
    input logic             rsp_valid,
    input logic [2:0]       rsp_fault,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_uncached,
    input logic [VA_W-1:0]  rsp_badvaddr
);
    assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_ukseg_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[VA_W-1:VA_W-3] == 3'b101)
        |=> (rsp_fault == 3'd0 && rsp_uncached));

    assert_misaligned_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_misaligned && req_vaddr[VA_W-1:VA_W-3] != 3'b101)
        |=> (rsp_fault == 3'd1 || rsp_fault == 3'd2));

    assert_vpn_low_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !small_pages |-> tlb_vpn[1:0] == 2'b00);

    assert_fault_no_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0 && !rsp_uncached));

    assert_badvaddr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> rsp_badvaddr == $past(req_vaddr));
endmodule

bind vat_xlate vat_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .VPN_W(VPN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .req_misaligned (req_misaligned),
    .small_pages    (small_pages),
    .tlb_vpn        (tlb_vpn),
    .rsp_valid      (rsp_valid),
    .rsp_fault      (rsp_fault),
    .rsp_paddr      (rsp_paddr),
    .rsp_uncached   (rsp_uncached),
    .rsp_badvaddr   (rsp_badvaddr)
);

// File: tb/vat_xlate_tb.sv
`timescale 1ns/100ps
module vat_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_asid = '0;
    logic        req_is_data = 1'b0;
    logic        req_misaligned = 1'b0;
    logic [31:0] status_word = '0;
    logic        small_pages = 1'b0;
    logic [20:0] tlb_vpn;
    logic [7:0]  tlb_asid;
    logic        tlb_hit = 1'b0;
    logic [4:0]  tlb_shift = 5'd12;
    logic [19:0] tlb_pfn_even = '0, tlb_pfn_odd = '0;
    logic        tlb_valid_even = 1'b0, tlb_valid_odd = 1'b0;
    logic        tlb_dirty_even = 1'b0, tlb_dirty_odd = 1'b0;
    logic [31:0] tlb_offmask = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [1:0]  rsp_mode;
    logic [31:0] rsp_paddr;
    logic        rsp_uncached;
    logic [7:0]  rsp_asid;
    logic [18:0] rsp_vpn2;
    logic [1:0]  rsp_vpn2x;
    logic [31:0] rsp_badvaddr;
    logic [18:0] rsp_ctx_badvpn2;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vat_xlate u_dut (.*);

    typedef struct packed {
        logic [31:0] va;
        logic        data;
        logic        mis;
        logic [31:0] st;
        logic        sp;
        logic        hit;
        logic [4:0]  sh;
        logic [19:0] pe;
        logic [19:0] po;
        logic        ve, vo, de, dd;
        logic [31:0] om;
        logic [2:0]  ef;
        logic [31:0] epa;
        logic        eu;
        logic [1:0]  em;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{32'h8001_2344,1'b0,1'b0,32'h00,1'b0,1'b0,5'd12,20'h0,20'h0,1'b0,1'b0,1'b0,1'b0,32'h0,   3'd0,32'h0001_2344,1'b0,2'd0},
        '{32'h8001_2344,1'b0,1'b0,32'h10,1'b0,1'b0,5'd12,20'h0,20'h0,1'b0,1'b0,1'b0,1'b0,32'h0,   3'd1,32'h0,1'b0,2'd2},
        '{32'h9000_0001,1'b1,1'b1,32'h00,1'b0,1'b0,5'd12,20'h0,20'h0,1'b0,1'b0,1'b0,1'b0,32'h0,   3'd2,32'h0,1'b0,2'd0},
        '{32'h9000_0000,1'b0,1'b0,32'h1A,1'b0,1'b0,5'd12,20'h0,20'h0,1'b0,1'b0,1'b0,1'b0,32'h0,   3'd0,32'h1000_0000,1'b0,2'd0},
        '{32'h9000_0000,1'b0,1'b0,32'h08,1'b0,1'b0,5'd12,20'h0,20'h0,1'b0,1'b0,1'b0,1'b0,32'h0,   3'd1,32'h0,1'b0,2'd1},
        '{32'h9000_0000,1'b1,1'b0,32'h18,1'b0,1'b0,5'd12,20'h0,20'h0,1'b0,1'b0,1'b0,1'b0,32'h0,   3'd2,32'h0,1'b0,2'd3},
        '{32'hA123_4568,1'b1,1'b1,32'h10,1'b0,1'b0,5'd12,20'h0,20'h0,1'b0,1'b0,1'b0,1'b0,32'h0,   3'd0,32'h0123_4568,1'b1,2'd2},
        '{32'h0040_1800,1'b0,1'b0,32'h00,1'b0,1'b0,5'd12,20'h0,20'h0,1'b0,1'b0,1'b0,1'b0,32'hFFF, 3'd3,32'h0,1'b0,2'd0},
        '{32'h0040_1800,1'b1,1'b0,32'h00,1'b1,1'b0,5'd12,20'h0,20'h0,1'b0,1'b0,1'b0,1'b0,32'hFFF, 3'd4,32'h0,1'b0,2'd0},
        '{32'h0040_1801,1'b1,1'b1,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b1,1'b1,1'b1,1'b1,32'hFFF, 3'd2,32'h0,1'b0,2'd0},
        '{32'h0040_0ABC,1'b0,1'b0,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b1,1'b1,1'b1,1'b1,32'hFFF, 3'd0,32'h1234_5ABC,1'b0,2'd0},
        '{32'h0040_1ABC,1'b0,1'b0,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b1,1'b1,1'b1,1'b1,32'hFFF, 3'd0,32'h0077_7ABC,1'b0,2'd0},
        '{32'h0040_1ABC,1'b0,1'b0,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b1,1'b0,1'b1,1'b1,32'hFFF, 3'd5,32'h0,1'b0,2'd0},
        '{32'h0040_0ABC,1'b1,1'b0,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b0,1'b1,1'b1,1'b1,32'hFFF, 3'd6,32'h0,1'b0,2'd0},
        '{32'h0040_0ABC,1'b1,1'b0,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b1,1'b1,1'b0,1'b1,32'hFFF, 3'd7,32'h0,1'b0,2'd0},
        '{32'h0040_0ABC,1'b0,1'b0,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b1,1'b1,1'b0,1'b1,32'hFFF, 3'd0,32'h1234_5ABC,1'b0,2'd0},
        '{32'h0040_0ABC,1'b1,1'b0,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b1,1'b1,1'b1,1'b0,32'hFFF, 3'd0,32'h1234_5ABC,1'b0,2'd0},
        '{32'h0040_6ABC,1'b0,1'b0,32'h00,1'b0,1'b1,5'd14,20'h00000,20'h00ABC,1'b0,1'b1,1'b1,1'b1,32'h3FFF,3'd0,32'h00AB_EABC,1'b0,2'd0},
        '{32'hE000_0ABC,1'b0,1'b0,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b1,1'b1,1'b1,1'b1,32'hFFF, 3'd0,32'h1234_5ABC,1'b1,2'd0},
        '{32'hE000_0ABC,1'b0,1'b0,32'h00,1'b0,1'b0,5'd12,20'h12345,20'h00777,1'b1,1'b1,1'b1,1'b1,32'hFFF, 3'd3,32'h0,1'b0,2'd0},
        '{32'h0040_1ABC,1'b1,1'b0,32'h00,1'b0,1'b1,5'd12,20'h12345,20'h00777,1'b1,1'b1,1'b1,1'b0,32'hFFF, 3'd7,32'h0,1'b0,2'd0}
    };

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string fault_tag(input vec_t v);
        if (v.va[31:29] == 3'b100) return "R2";
        if (v.va[31:29] == 3'b101) return "R3";
        case (v.ef)
            3'd1, 3'd2: return "R5";
            3'd3, 3'd4: return "R6";
            3'd5, 3'd6: return "R7";
            3'd7:       return "R8";
            default:    return "R10";  // includes R8 instruction-ignores-dirty case
        endcase
    endfunction

    function automatic logic [20:0] exp_vpn(input vec_t v);
        logic [20:0] p;
        p = v.va[31:11];
        if (!v.sp) p[1:0] = 2'b00;
        return p;
    endfunction

    task automatic drive(input vec_t v, input logic [7:0] asid);
        req_valid      = 1'b1;
        req_vaddr      = v.va;
        req_asid       = asid;
        req_is_data    = v.data;
        req_misaligned = v.mis;
        status_word    = v.st;
        small_pages    = v.sp;
        tlb_hit        = v.hit;
        tlb_shift      = v.sh;
        tlb_pfn_even   = v.pe;
        tlb_pfn_odd    = v.po;
        tlb_valid_even = v.ve;
        tlb_valid_odd  = v.vo;
        tlb_dirty_even = v.de;
        tlb_dirty_odd  = v.dd;
        tlb_offmask    = v.om;
    endtask

    initial begin : watchdog
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R12", "reset rsp_fault", 64'(rsp_fault), 64'd0);
        chk("R12", "reset rsp_paddr", 64'(rsp_paddr), 64'd0);
        chk("R12", "reset rsp_badvaddr", 64'(rsp_badvaddr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [20:0] pv;
            logic [7:0]  asid;
            logic        tf;
            v    = VECS[i];
            asid = 8'h30 + 8'(i);
            drive(v, asid);
            #1;
            pv = exp_vpn(v);
            if (v.va[31:30] != 2'b10) begin
                chk("R4", "tlb_vpn", 64'(tlb_vpn), 64'(pv));
            end
            chk("R4", "tlb_asid", 64'(tlb_asid), 64'(asid));
            @(negedge clk);
            tf = (v.ef >= 3'd3);
            chk("R12", "rsp_valid", 64'(rsp_valid), 64'd1);
            chk(fault_tag(v), "rsp_fault", 64'(rsp_fault), 64'(v.ef));
            chk("R1", "rsp_mode", 64'(rsp_mode), 64'(v.em));
            chk("R10", "rsp_paddr", 64'(rsp_paddr), 64'(v.epa));
            chk("R11", "rsp_uncached", 64'(rsp_uncached), 64'(v.eu));
            chk("R9", "rsp_badvaddr", 64'(rsp_badvaddr),
                (v.ef != 3'd0) ? 64'(v.va) : 64'd0);
            chk("R9", "report fields",
                {rsp_asid, rsp_vpn2, rsp_vpn2x, rsp_ctx_badvpn2},
                tf ? {asid, pv[20:2], pv[1:0], pv[20:2]} : 48'd0);
        end

        // R12: idle request yields no response next cycle
        req_valid = 1'b0;
        @(negedge clk);
        chk("R12", "idle rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R12", "idle rsp_fault", 64'(rsp_fault), 64'd0);

        // R3: uncached segment with non-kernel invalid mode and misaligned, instruction
        drive(VECS[6], 8'h11);
        req_is_data = 1'b0;
        status_word = 32'h18;
        @(negedge clk);
        chk("R3", "uncached seg invalid mode fault", 64'(rsp_fault), 64'd0);
        chk("R3", "uncached seg paddr", 64'(rsp_paddr), 64'h0123_4568);
        req_valid = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule